// File: doc/BRIEF.md
# I2C Slave Target with Clock Stretching

This block is the target side of an I2C link. It follows the bus from its own system clock. A two-stage synchronizer samples the SCL and SDA lines, and edge logic picks out SCL edges and the START and STOP conditions. After a START the block shifts in a 7-bit address and a direction bit. It answers only when the address equals its programmable own address. Bytes that the controller writes go into a 16-entry receive queue. Bytes that the controller reads come from a 16-entry transmit queue.

A controller may ask for read data before the host has queued any. In that case the block holds SCL low for as long as needed and raises a request flag. It lets go of SCL once the host pushes a byte, and then sends that byte. The host can also clear the enable input to drop a stalled transfer. Both lines are open-drain. The outputs `scl_low` and `sda_low` mean "pull this line low", and the line inputs read back the wired level on the bus.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, the own address is 0x55. Both line drivers are released, `rd_req` and `rx_ovf` are 0, `rx_empty` is 1, and `rx_full` and `tx_full` are 0.
- R2: A pulse on `addr_load` copies `addr_value` into the own address only while `enable` is 0. While `enable` is 1 the pulse is ignored, and the address seen on `slave_addr` and used for matching does not change.
- R3: SDA falling while SCL is high is a START and begins the address phase. SDA rising while SCL is high is a STOP and returns the block to idle. The block changes its own SDA drive only while SCL is low, so it never creates a START or a STOP.
- R4: The first byte after a START is sent MSB first. It holds the 7 address bits followed by the direction bit, where 1 means read. The block pulls SDA low in the ninth clock (ACK) only when the address matches. On a mismatch it stays silent until the next START.
- R5: In a write, every received byte is ACKed and pushed into the receive queue in arrival order. This goes on until a STOP or a START.
- R6: If the receive queue is full when a byte completes, the byte is NACKed and discarded, and `rx_ovf` goes to 1. `rx_ovf` stays at 1 until `enable` is 0.
- R7: In a read, bytes come from the transmit queue MSB first. The block keeps sending while the controller ACKs. A NACK from the controller ends the block's transmission.
- R8: If a read byte is due and the transmit queue is empty, the block holds SCL low and sets `rd_req` to 1 until a byte is pushed. It then sends that byte.
- R9: When `enable` is 0 at a clock edge, after that edge `scl_low`, `sda_low` and `rd_req` are 0 and the transfer is dropped.
- R10: A repeated START without a STOP restarts the address phase. A write followed by a read in one transfer works.
- R11: Each queue holds exactly 16 bytes. `tx_full` is 1 after 16 pushes, and a 17th push is ignored. The receive queue accepts 16 bytes before it reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 releases the bus and drops the transfer |
| addr_load | input | 1 | Load strobe for the own address (works only while disabled) |
| addr_value | input | 7 | New own address |
| slave_addr | output | 7 | Current own address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low | output | 1 | 1 = pull SCL low (stretch) |
| sda_low | output | 1 | 1 = pull SDA low |
| tx_data | input | 8 | Byte to queue for reads |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| rx_data | output | 8 | Oldest received byte (show-ahead) |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rd_req | output | 1 | Read data wanted; SCL is being held low |
| rx_ovf | output | 1 | Sticky flag: a byte was refused because the queue was full |

## Verification
Two events can collide. A host push can arrive while the block is holding SCL low, and the enable can drop during that same stall. The bench waits until `rd_req` is 1, checks that SCL stays low for many cycles, and then does one of two things: pushes a byte, or clears `enable`. For the push, it judges that `rd_req` falls and that the controller reads exactly the pushed byte. For the disable, it judges that both drivers let go within one clock, that the line then reads all ones, and that a later push makes no difference to the bus until a new transfer starts.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ADDR_AT_RESET = 7'h55;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_WAIT,
    ST_RD_SETUP,
    ST_RD_DATA,
    ST_RD_ACK
  } state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // bit 1 = SCL, bit 0 = SDA; idle bus reads high
  logic [1:0] chain [STAGES];
  logic [1:0] prev_q;
  logic       scl_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 2'b11;
          else        chain[0] <= {scl_in, sda_in};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 2'b11;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= chain[STAGES-1];
  end

  assign scl_s     = chain[STAGES-1][1];
  assign sda_s     = chain[STAGES-1][0];
  assign scl_rise  = scl_s & ~prev_q[1];
  assign scl_fall  = ~scl_s & prev_q[1];
  assign start_det = scl_s & prev_q[1] & ~sda_s & prev_q[0];
  assign stop_det  = scl_s & prev_q[1] & sda_s & ~prev_q[0];
endmodule

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] tx_dout,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic [DATA_W-1:0] rx_din,
  input  logic              rx_full,
  output logic              rx_push,
  output logic              scl_low,
  output logic              sda_low,
  output logic              rd_req,
  output logic              rx_ovf
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  state_e            state_q, state_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shin_q, shin_d;
  logic [DATA_W-1:0] shout_q, shout_d;
  logic              done_q, done_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              sda_q, sda_d;
  logic              scl_q, scl_d;
  logic              ovf_q, ovf_d;
  logic              want_byte;

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    shin_d    = shin_q;
    shout_d   = shout_q;
    done_d    = done_q;
    rw_d      = rw_q;
    mack_d    = mack_q;
    sda_d     = sda_q;
    scl_d     = scl_q;
    ovf_d     = ovf_q;
    rx_push   = 1'b0;
    tx_pop    = 1'b0;
    want_byte = 1'b0;

    if (!enable) begin
      state_d = ST_IDLE;
      sda_d   = 1'b0;
      scl_d   = 1'b0;
      done_d  = 1'b0;
      ovf_d   = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      done_d  = 1'b0;
      sda_d   = 1'b0;
      scl_d   = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
      sda_d   = 1'b0;
      scl_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR_DATA: begin
          if (scl_rise) begin
            shin_d = {shin_q[DATA_W-2:0], sda_s};
            bit_d  = bit_q + CNT_W'(1);
            if (bit_q == LAST_BIT) done_d = 1'b1;
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            bit_d  = '0;
            if (state_q == ST_ADDR) begin
              if (shin_q[DATA_W-1:1] == own_addr) begin
                sda_d   = 1'b1;
                rw_d    = shin_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (!rx_full) begin
              rx_push = 1'b1;
              sda_d   = 1'b1;
              state_d = ST_WR_ACK;
            end else begin
              ovf_d   = 1'b1;
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_d = 1'b0;
            if (rw_q) want_byte = 1'b1;
            else      state_d   = ST_WR_DATA;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_d   = 1'b0;
            state_d = ST_WR_DATA;
          end
        end
        ST_RD_WAIT: begin
          if (!tx_empty) begin
            tx_pop  = 1'b1;
            shout_d = tx_dout;
            sda_d   = ~tx_dout[DATA_W-1];
            bit_d   = '0;
            state_d = ST_RD_SETUP;
          end
        end
        ST_RD_SETUP: begin
          scl_d   = 1'b0;
          state_d = ST_RD_DATA;
        end
        ST_RD_DATA: begin
          if (scl_fall) begin
            bit_d = bit_q + CNT_W'(1);
            if (bit_q == LAST_BIT) begin
              sda_d   = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              shout_d = {shout_q[DATA_W-2:0], 1'b0};
              sda_d   = ~shout_q[DATA_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) want_byte = 1'b1;
            else        state_d   = ST_IDLE;
          end
        end
        default: ;
      endcase

      if (want_byte) begin
        if (!tx_empty) begin
          tx_pop  = 1'b1;
          shout_d = tx_dout;
          sda_d   = ~tx_dout[DATA_W-1];
          bit_d   = '0;
          state_d = ST_RD_DATA;
        end else begin
          scl_d   = 1'b1;
          state_d = ST_RD_WAIT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      done_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      sda_q   <= 1'b0;
      scl_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shin_q  <= shin_d;
      shout_q <= shout_d;
      done_q  <= done_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      sda_q   <= sda_d;
      scl_q   <= scl_d;
      ovf_q   <= ovf_d;
    end
  end

  assign rx_din  = shin_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;
  assign rd_req  = (state_q == ST_RD_WAIT);
  assign rx_ovf  = ovf_q;
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
  import i2cs_pkg::*;
#(
  parameter int QUEUE_DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_value,
  output logic [ADDR_W-1:0] slave_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low,
  output logic              sda_low,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_push,
  output logic              tx_full,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_pop,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rd_req,
  output logic              rx_ovf
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DATA_W-1:0] tx_dout, rx_din;
  logic              tx_empty, tx_pop, rx_push;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    addr_d = addr_q;
    if (addr_load && !enable) addr_d = addr_value;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) addr_q <= ADDR_AT_RESET;
    else            addr_q <= addr_d;
  end
  assign slave_addr = addr_q;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_in    (scl_i),
    .sda_in    (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_fifo #(.WIDTH(DATA_W), .DEPTH(QUEUE_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (tx_push),
    .din   (tx_data),
    .pop   (tx_pop),
    .dout  (tx_dout),
    .empty (tx_empty),
    .full  (tx_full)
  );

  i2cs_fifo #(.WIDTH(DATA_W), .DEPTH(QUEUE_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (rx_push),
    .din   (rx_din),
    .pop   (rx_pop),
    .dout  (rx_data),
    .empty (rx_empty),
    .full  (rx_full)
  );

  i2cs_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .enable    (enable),
    .own_addr  (addr_q),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .tx_dout   (tx_dout),
    .tx_empty  (tx_empty),
    .tx_pop    (tx_pop),
    .rx_din    (rx_din),
    .rx_full   (rx_full),
    .rx_push   (rx_push),
    .scl_low   (scl_low),
    .sda_low   (sda_low),
    .rd_req    (rd_req),
    .rx_ovf    (rx_ovf)
  );
endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       scl_i,
  input logic       scl_low,
  input logic       sda_low,
  input logic       rd_req,
  input logic       rx_ovf,
  input logic       rx_full,
  input logic [6:0] slave_addr
);
  AST_RELEASE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_low && !sda_low && !rd_req)); // R9

  AST_REQ_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> scl_low); // R8

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> $stable(slave_addr)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> $past(rx_full)); // R6

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(sda_low)) |-> !$past(scl_i)); // R3
endmodule

bind i2c_stretch_slave i2cs_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .scl_i      (scl_i),
  .scl_low    (scl_low),
  .sda_low    (sda_low),
  .rd_req     (rd_req),
  .rx_ovf     (rx_ovf),
  .rx_full    (rx_full),
  .slave_addr (slave_addr)
);

// File: tb/i2c_stretch_slave_test.sv
module i2c_stretch_slave_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n, enable, addr_load;
  logic [6:0] addr_value, slave_addr;
  logic       scl_m, sda_m, scl_line, sda_line;
  logic       scl_low, sda_low;
  logic [7:0] tx_data, rx_data;
  logic       tx_push, tx_full, rx_pop, rx_empty, rx_full, rd_req, rx_ovf;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign scl_line = scl_m & ~scl_low;
  assign sda_line = sda_m & ~sda_low;

  i2c_stretch_slave uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr_load(addr_load),
    .addr_value(addr_value), .slave_addr(slave_addr),
    .scl_i(scl_line), .sda_i(sda_line), .scl_low(scl_low), .sda_low(sda_low),
    .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full),
    .rx_data(rx_data), .rx_pop(rx_pop), .rx_empty(rx_empty), .rx_full(rx_full),
    .rd_req(rd_req), .rx_ovf(rx_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference model: own address and release-on-disable
  logic [6:0] m_addr;
  logic       en_edge;
  always @(posedge clk) begin
    en_edge <= enable;
    if (!rst_n) m_addr <= 7'h55;
    else if (addr_load && !enable) m_addr <= addr_value;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 addr model", slave_addr, m_addr);
      if (!en_edge) begin
        chk("R9 scl released", scl_low, 0);
        chk("R9 sda released", sda_low, 0);
      end
      if (rd_req) chk("R8 stretch while req", scl_low, 1);
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wcyc(Q);
    scl_m = 1'b1; wait_scl_high(); wcyc(Q);
    sda_m = 1'b0; wcyc(Q);
    scl_m = 1'b0; wcyc(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wcyc(Q);
    scl_m = 1'b1; wait_scl_high(); wcyc(Q);
    sda_m = 1'b1; wcyc(Q);
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; wcyc(Q);
    scl_m = 1'b1; wait_scl_high(); wcyc(Q);
    scl_m = 1'b0; wcyc(Q);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wcyc(Q);
    scl_m = 1'b1; wait_scl_high(); wcyc(Q);
    b = sda_line;
    scl_m = 1'b0; wcyc(Q);
  endtask

  task automatic byte_w(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(v[i]);
    bit_r(b);
    acked = ~b;
  endtask

  task automatic byte_r(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_r(b);
      v[i] = b;
    end
    bit_w(~ack);
  endtask

  task automatic host_push(input logic [7:0] v);
    tx_data = v; tx_push = 1'b1; wcyc(1);
    tx_push = 1'b0;
  endtask

  task automatic rx_expect(input string req, input logic [7:0] v);
    chk(req, rx_empty, 0);
    chk(req, rx_data, v);
    rx_pop = 1'b1; wcyc(1);
    rx_pop = 1'b0;
  endtask

  task automatic wait_req();
    while (rd_req !== 1'b1) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    rst_n = 1'b0; enable = 1'b0; addr_load = 1'b0; addr_value = '0;
    scl_m = 1'b1; sda_m = 1'b1; tx_data = '0; tx_push = 1'b0; rx_pop = 1'b0;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);

    // R1 reset state
    chk("R1 addr", slave_addr, 8'h55);
    chk("R1 scl", scl_low, 0);
    chk("R1 sda", sda_low, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 ovf", rx_ovf, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_full", tx_full, 0);
    enable = 1'b1; wcyc(3);

    // R5 plain write to own address
    i2c_start();
    byte_w({7'h55, 1'b0}, ack); chk("R4 addr ack", ack, 1);
    byte_w(8'hA1, ack); chk("R5 ack b0", ack, 1);
    byte_w(8'h00, ack); chk("R5 ack b1", ack, 1);
    byte_w(8'hFF, ack); chk("R5 ack b2", ack, 1);
    i2c_stop(); wcyc(5);
    chk("R3 idle after stop", sda_low, 0);
    rx_expect("R5 byte0", 8'hA1);
    rx_expect("R5 byte1", 8'h00);
    rx_expect("R5 byte2", 8'hFF);
    chk("R5 drained", rx_empty, 1);

    // R4 other address is ignored
    i2c_start();
    byte_w({7'h21, 1'b0}, ack); chk("R4 mismatch nack", ack, 0);
    byte_w(8'h99, ack); chk("R4 silent after mismatch", ack, 0);
    i2c_stop(); wcyc(5);
    chk("R4 nothing stored", rx_empty, 1);

    // R6 / R11 receive queue overflow
    i2c_start();
    byte_w({7'h55, 1'b0}, ack); chk("R4 addr ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      byte_w(8'h40 + 8'(i), ack); chk("R11 rx accept", ack, 1);
    end
    byte_w(8'hEE, ack); chk("R6 full nack", ack, 0);
    i2c_stop(); wcyc(5);
    chk("R6 ovf set", rx_ovf, 1);
    chk("R11 rx full", rx_full, 1);
    for (int i = 0; i < 16; i++) rx_expect("R11 rx order", 8'h40 + 8'(i));
    chk("R6 byte discarded", rx_empty, 1);
    chk("R6 ovf sticky", rx_ovf, 1);

    // R2 address load ignored while enabled, accepted while disabled
    addr_value = 7'h2A; addr_load = 1'b1; wcyc(1); addr_load = 1'b0; wcyc(2);
    chk("R2 ignored when enabled", slave_addr, 8'h55);
    enable = 1'b0; wcyc(2);
    chk("R6 ovf cleared by disable", rx_ovf, 0);
    addr_load = 1'b1; wcyc(1); addr_load = 1'b0; wcyc(1);
    chk("R2 loaded when disabled", slave_addr, 8'h2A);
    enable = 1'b1; wcyc(3);
    i2c_start();
    byte_w({7'h55, 1'b0}, ack); chk("R2 old address nacked", ack, 0);
    i2c_stop();

    // R7 read with queued data
    host_push(8'hA5); host_push(8'h3C);
    i2c_start();
    byte_w({7'h2A, 1'b1}, ack); chk("R4 read addr ack", ack, 1);
    byte_r(d, 1'b1); chk("R7 read byte0", d, 8'hA5);
    byte_r(d, 1'b0); chk("R7 read byte1", d, 8'h3C);
    i2c_stop(); wcyc(5);
    chk("R7 released after nack", sda_low, 0);

    // R8 stretch until host supplies a byte
    fork
      begin
        i2c_start();
        byte_w({7'h2A, 1'b1}, ack);
        byte_r(d, 1'b0);
        i2c_stop();
      end
      begin
        wait_req();
        wcyc(40);
        chk("R8 scl held", scl_line, 0);
        chk("R8 req high", rd_req, 1);
        host_push(8'hC7);
        wcyc(2);
        chk("R8 req drops", rd_req, 0);
      end
    join
    chk("R8 stretched byte", d, 8'hC7);

    // R9 disable during a stretch
    fork
      begin
        i2c_start();
        byte_w({7'h2A, 1'b1}, ack);
        byte_r(d, 1'b0);
        i2c_stop();
      end
      begin
        wait_req();
        wcyc(20);
        enable = 1'b0;
        wcyc(2);
        chk("R9 scl off", scl_low, 0);
        chk("R9 sda off", sda_low, 0);
        chk("R9 req off", rd_req, 0);
      end
    join
    chk("R9 bus idle data", d, 8'hFF);
    enable = 1'b1; wcyc(3);

    // R10 write then repeated START and read
    host_push(8'h5A);
    i2c_start();
    byte_w({7'h2A, 1'b0}, ack); chk("R10 write addr", ack, 1);
    byte_w(8'h11, ack); chk("R10 write byte", ack, 1);
    i2c_start();
    byte_w({7'h2A, 1'b1}, ack); chk("R10 restart addr", ack, 1);
    byte_r(d, 1'b0); chk("R10 read after restart", d, 8'h5A);
    i2c_stop(); wcyc(5);
    rx_expect("R10 written byte", 8'h11);

    // R11 transmit queue depth; 17th push ignored
    for (int i = 0; i < 16; i++) host_push(8'h80 + 8'(i));
    chk("R11 tx full", tx_full, 1);
    host_push(8'hFE);
    i2c_start();
    byte_w({7'h2A, 1'b1}, ack); chk("R11 read addr", ack, 1);
    for (int i = 0; i < 16; i++) begin
      byte_r(d, (i != 15));
      chk("R11 tx order", d, 8'h80 + 8'(i));
    end
    i2c_stop(); wcyc(5);
    chk("R11 tx not full", tx_full, 0);
    fork
      begin
        i2c_start();
        byte_w({7'h2A, 1'b1}, ack);
        byte_r(d, 1'b0);
        i2c_stop();
      end
      begin
        wait_req();
        wcyc(5);
        host_push(8'h01);
      end
    join
    chk("R11 extra push dropped", d, 8'h01);

    wcyc(10);
    summary();
    $finish;
  end
endmodule